// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is a configuration register file that a host reaches through a pair of byte addresses. The lower address (bus address bit 0) is the index port: a byte written there picks a register. The upper address (bus address bit 1, the base plus one) is the data port: a read or write there acts on the register that the index names. Until the host writes a fixed four-byte key to the index port, the file stays sealed. While sealed, every read returns 0xFF and nothing but the key detector reacts to a write.

Once open, the file offers a small global area and a banked area. The global area holds a control register, a device selector, and three read-only identity registers (two identifier bytes and a version nibble). The banked area, at indices 0x30 and above, is repeated once per logical device, and the selector picks which copy is seen. Each device copy has an enable bit, a 16-bit I/O base and an interrupt number, each with its own reset default. The host seals the file again by writing the exit byte to the index port, or by setting bit 1 of the control register.

Top module: `kcfg_port_top`

## Requirements
- R1: When `bus_addr` is 0 the index port is addressed; when it is 1 the data port is addressed. A data access reaches the register whose number was last written to the index port. `bus_rdata` is 0x00 whenever `bus_rd` is low.
- R2: The file opens after the index port receives the bytes 0x87, 0x01 and 0x55 in that order, followed by a final byte. The final byte is 0x55 when the `PORT_BASE` parameter equals 0x002E, and 0xAA for any other base.
- R3: Any wrong byte in the key returns the detector to its start. A wrong byte equal to 0x87 counts as the first byte of a new attempt.
- R4: While the file is sealed, reads of either port return 0xFF, data-port writes change nothing, and index-port writes are not stored as the index.
- R5: Writing 0xAA to the index port while the file is open seals it. That byte is not stored as the index.
- R6: A data write to register 0x02 with bit 1 set seals the file. The same write with bit 1 clear leaves the file open. Register 0x02 reads as 0x00.
- R7: Register 0x20 returns `CHIP_ID[15:8]`, register 0x21 returns `CHIP_ID[7:0]`, and register 0x22 returns `{4'b0000, CHIP_VER}`.
- R8: Register 0x07 is the logical device selector. It stores any 8-bit value and reads it back.
- R9: In the device chosen by the selector, register 0x30 keeps bit 0 as the enable bit and reads its other bits as 0. Registers 0x60 and 0x61 hold the high and low bytes of the I/O base. Register 0x70 keeps the interrupt number in its low nibble and reads its high nibble as 0. Each device holds its own copy.
- R10: After reset every device has its enable bit clear. Device 1 has base 0x03F8 and interrupt 4, device 2 has base 0x02F8 and interrupt 3, and all other devices have base 0x0000 and interrupt 0.
- R11: A register number that is not implemented, or any banked register while the selector is above `MAX_LDN`, reads 0xFF on the data port and ignores writes. The selector value itself is still stored.
- R12: While the file is open, a read of the index port returns the last index that was stored.
- R13: A read in the same cycle as a write sees the state from before that write. This covers key completion, sealing, and register updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current state |

## Verification
The key detector and the sealing logic can act in the same cycle as a read, because read data is combinational and every state change lands on the next edge. The bench writes the final key byte while it reads the index port, and expects 0xFF. It writes the exit byte while it reads the index port, and expects the old index. It writes a banked register while it reads that same register, and expects the old value. In each case a plain read in the next cycle must show the new state.

// File: rtl/kcfg_pkg.sv
package kcfg_pkg;

    localparam logic [7:0] REG_CTRL    = 8'h02;
    localparam logic [7:0] REG_SEL     = 8'h07;
    localparam logic [7:0] REG_ID_HI   = 8'h20;
    localparam logic [7:0] REG_ID_LO   = 8'h21;
    localparam logic [7:0] REG_VER     = 8'h22;
    localparam logic [7:0] REG_ENA     = 8'h30;
    localparam logic [7:0] REG_BASE_HI = 8'h60;
    localparam logic [7:0] REG_BASE_LO = 8'h61;
    localparam logic [7:0] REG_IRQ     = 8'h70;
    localparam logic [7:0] BANK_START  = 8'h30;

    localparam logic [7:0] KEY_FIRST   = 8'h87;
    localparam logic [7:0] KEY_SECOND  = 8'h01;
    localparam logic [7:0] KEY_THIRD   = 8'h55;
    localparam logic [7:0] SEAL_BYTE   = 8'hAA;
    localparam logic [7:0] EMPTY_READ  = 8'hFF;
    localparam int         CTRL_SEAL_BIT = 1;

    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_ONE  = 2'd1,
        KS_TWO  = 2'd2,
        KS_LAST = 2'd3
    } key_stage_t;

    typedef struct packed {
        logic        ena;
        logic [15:0] io_base;
        logic [3:0]  irq;
    } dev_regs_t;

    typedef struct packed {
        logic       hit;
        logic [7:0] data;
    } rd_resp_t;

    function automatic logic [7:0] key_final(input logic [15:0] base);
        return (base == 16'h002E) ? 8'h55 : 8'hAA;
    endfunction

    function automatic logic [7:0] key_expect(input key_stage_t st, input logic [7:0] fin);
        logic [7:0] b;
        case (st)
            KS_IDLE: b = KEY_FIRST;
            KS_ONE:  b = KEY_SECOND;
            KS_TWO:  b = KEY_THIRD;
            default: b = fin;
        endcase
        return b;
    endfunction

    function automatic dev_regs_t dev_default(input int n);
        dev_regs_t d;
        d = '0;
        case (n)
            1: begin d.io_base = 16'h03F8; d.irq = 4'd4; end
            2: begin d.io_base = 16'h02F8; d.irq = 4'd3; end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/kcfg_key_fsm.sv
module kcfg_key_fsm
    import kcfg_pkg::*;
#(
    parameter logic [15:0] PORT_BASE = 16'h002E
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       feed,
    input  logic [7:0] byte_in,
    output logic       unlock
);
    localparam logic [7:0] FINAL_BYTE = key_final(PORT_BASE);

    key_stage_t stage_q;
    logic       match;

    always_comb begin
        match  = (byte_in == key_expect(stage_q, FINAL_BYTE));
        unlock = feed && match && (stage_q == KS_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= KS_IDLE;
        end else if (feed) begin
            if (match) begin
                stage_q <= (stage_q == KS_LAST) ? KS_IDLE : key_stage_t'(stage_q + 2'd1);
            end else if (byte_in == KEY_FIRST) begin
                stage_q <= KS_ONE;
            end else begin
                stage_q <= KS_IDLE;
            end
        end
    end
endmodule

// File: rtl/kcfg_dev_bank.sv
module kcfg_dev_bank
    import kcfg_pkg::*;
#(
    parameter int MAX_LDN = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] sel,
    input  logic [7:0] reg_idx,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output rd_resp_t   resp
);
    localparam int NUM_DEV = MAX_LDN + 1;

    dev_regs_t dev_q [NUM_DEV];
    logic      sel_ok;
    logic      reg_known;

    always_comb begin
        sel_ok    = (int'(sel) <= MAX_LDN);
        reg_known = (reg_idx == REG_ENA) || (reg_idx == REG_BASE_HI) ||
                    (reg_idx == REG_BASE_LO) || (reg_idx == REG_IRQ);
    end

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        logic take;
        assign take = wr_en && sel_ok && (sel == 8'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                dev_q[g] <= dev_default(g);
            end else if (take) begin
                case (reg_idx)
                    REG_ENA:     dev_q[g].ena           <= wdata[0];
                    REG_BASE_HI: dev_q[g].io_base[15:8] <= wdata;
                    REG_BASE_LO: dev_q[g].io_base[7:0]  <= wdata;
                    REG_IRQ:     dev_q[g].irq           <= wdata[3:0];
                    default: ;
                endcase
            end
        end
    end

    dev_regs_t cur;

    always_comb begin
        cur = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (sel == 8'(i)) cur = dev_q[i];
        end
        resp.hit = sel_ok && reg_known;
        case (reg_idx)
            REG_ENA:     resp.data = {7'd0, cur.ena};
            REG_BASE_HI: resp.data = cur.io_base[15:8];
            REG_BASE_LO: resp.data = cur.io_base[7:0];
            REG_IRQ:     resp.data = {4'd0, cur.irq};
            default:     resp.data = EMPTY_READ;
        endcase
    end
endmodule

// File: rtl/kcfg_glob_regs.sv
module kcfg_glob_regs
    import kcfg_pkg::*;
#(
    parameter logic [15:0] CHIP_ID  = 16'h8712,
    parameter logic [3:0]  CHIP_VER = 4'h3
) (
    input  logic [7:0] reg_idx,
    input  logic [7:0] sel,
    output rd_resp_t   resp
);
    always_comb begin
        resp.hit = 1'b1;
        case (reg_idx)
            REG_CTRL:  resp.data = 8'h00;
            REG_SEL:   resp.data = sel;
            REG_ID_HI: resp.data = CHIP_ID[15:8];
            REG_ID_LO: resp.data = CHIP_ID[7:0];
            REG_VER:   resp.data = {4'd0, CHIP_VER};
            default: begin
                resp.hit  = 1'b0;
                resp.data = EMPTY_READ;
            end
        endcase
    end
endmodule

// File: rtl/kcfg_port_top.sv
module kcfg_port_top
    import kcfg_pkg::*;
#(
    parameter logic [15:0] PORT_BASE = 16'h002E,
    parameter logic [15:0] CHIP_ID   = 16'h8712,
    parameter logic [3:0]  CHIP_VER  = 4'h3,
    parameter int          MAX_LDN   = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    logic       open_q;
    logic [7:0] index_q;
    logic [7:0] sel_q;

    logic idx_wr, dat_wr, key_feed, key_done;
    logic seal_idx, seal_ctrl, bank_wr;
    rd_resp_t glob_resp, bank_resp;

    always_comb begin
        idx_wr    = bus_wr && !bus_addr;
        dat_wr    = bus_wr && bus_addr;
        key_feed  = idx_wr && !open_q;
        seal_idx  = idx_wr && open_q && (bus_wdata == SEAL_BYTE);
        seal_ctrl = dat_wr && open_q && (index_q == REG_CTRL) && bus_wdata[CTRL_SEAL_BIT];
        bank_wr   = dat_wr && open_q && (index_q >= BANK_START);
    end

    kcfg_key_fsm #(.PORT_BASE(PORT_BASE)) u_key (
        .clk     (clk),
        .rst     (rst),
        .feed    (key_feed),
        .byte_in (bus_wdata),
        .unlock  (key_done)
    );

    kcfg_glob_regs #(.CHIP_ID(CHIP_ID), .CHIP_VER(CHIP_VER)) u_glob (
        .reg_idx (index_q),
        .sel     (sel_q),
        .resp    (glob_resp)
    );

    kcfg_dev_bank #(.MAX_LDN(MAX_LDN)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel_q),
        .reg_idx (index_q),
        .wr_en   (bank_wr),
        .wdata   (bus_wdata),
        .resp    (bank_resp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            index_q <= 8'h00;
            sel_q   <= 8'h00;
        end else begin
            if (key_done) begin
                open_q <= 1'b1;
            end else if (seal_idx || seal_ctrl) begin
                open_q <= 1'b0;
            end
            if (idx_wr && open_q && !seal_idx) begin
                index_q <= bus_wdata;
            end
            if (dat_wr && open_q && (index_q == REG_SEL)) begin
                sel_q <= bus_wdata;
            end
        end
    end

    always_comb begin
        if (!bus_rd) begin
            bus_rdata = 8'h00;
        end else if (!open_q) begin
            bus_rdata = EMPTY_READ;
        end else if (!bus_addr) begin
            bus_rdata = index_q;
        end else if (glob_resp.hit) begin
            bus_rdata = glob_resp.data;
        end else if (bank_resp.hit) begin
            bus_rdata = bank_resp.data;
        end else begin
            bus_rdata = EMPTY_READ;
        end
    end
endmodule

// File: rtl/kcfg_port_chk.sv
module kcfg_port_chk #(
    parameter logic [15:0] PORT_BASE = 16'h002E,
    parameter logic [15:0] CHIP_ID   = 16'h8712
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       open_q,
    input logic [7:0] index_q,
    input logic [7:0] sel_q
);
    localparam logic [7:0] FIN = (PORT_BASE == 16'h002E) ? 8'h55 : 8'hAA;

    assert_open_after_key_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(open_q) |-> $past(bus_wr && !bus_addr && bus_wdata == FIN));

    assert_sealed_read_R4: assert property (@(posedge clk) disable iff (rst)
        (!open_q && bus_rd) |-> bus_rdata == 8'hFF);

    assert_sealed_index_R4: assert property (@(posedge clk) disable iff (rst)
        (!open_q && bus_wr && !bus_addr) |=> $stable(index_q));

    assert_sealed_data_R4: assert property (@(posedge clk) disable iff (rst)
        (!open_q && bus_wr && bus_addr) |=> $stable(sel_q));

    assert_seal_byte_R5: assert property (@(posedge clk) disable iff (rst)
        (open_q && bus_wr && !bus_addr && bus_wdata == 8'hAA) |=> !open_q);

    assert_seal_ctrl_R6: assert property (@(posedge clk) disable iff (rst)
        (open_q && bus_wr && bus_addr && index_q == 8'h02 && bus_wdata[1]) |=> !open_q);

    assert_id_high_R7: assert property (@(posedge clk) disable iff (rst)
        (open_q && bus_rd && bus_addr && index_q == 8'h20) |-> bus_rdata == CHIP_ID[15:8]);

    assert_index_echo_R12: assert property (@(posedge clk) disable iff (rst)
        (open_q && bus_rd && !bus_addr &&
         $past(open_q && bus_wr && !bus_addr && bus_wdata != 8'hAA))
        |-> bus_rdata == $past(bus_wdata));
endmodule

bind kcfg_port_top kcfg_port_chk #(.PORT_BASE(PORT_BASE), .CHIP_ID(CHIP_ID)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .open_q    (open_q),
    .index_q   (index_q),
    .sel_q     (sel_q)
);

// File: tb/kcfg_port_top_tb_top.sv
`timescale 1ns/1ps
module kcfg_port_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] rdata_main;
    logic [7:0] rdata_alt;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    kcfg_port_top #(.PORT_BASE(16'h002E), .CHIP_ID(16'h8712), .CHIP_VER(4'h3), .MAX_LDN(10)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_main));

    kcfg_port_top #(.PORT_BASE(16'h004E), .CHIP_ID(16'h8712), .CHIP_VER(4'h3), .MAX_LDN(10)) dut_alt_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_alt));

    task automatic judge(input logic [7:0] act, input logic [7:0] expv, input string tag);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, expv);
        end
    endtask

    // monitor: pops one expectation per read strobe
    always @(negedge clk) begin
        if (!rst && bus_rd) begin
            if (exp_q.size() == 0) begin
                judge(rdata_main, 8'hxx, "scoreboard empty");
            end else begin
                judge(rdata_main, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic drive(input logic a, input logic w, input logic r,
                         input logic [7:0] d, input logic [7:0] expv, input string tag);
        @(posedge clk); #1;
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
        if (r) begin
            exp_q.push_back(expv);
            tag_q.push_back(tag);
        end
    endtask

    task automatic wi(input logic [7:0] d); drive(1'b0, 1'b1, 1'b0, d, 8'h00, ""); endtask
    task automatic wd(input logic [7:0] d); drive(1'b1, 1'b1, 1'b0, d, 8'h00, ""); endtask
    task automatic ri(input logic [7:0] e, input string t); drive(1'b0, 1'b0, 1'b1, 8'h00, e, t); endtask
    task automatic rd(input logic [7:0] e, input string t); drive(1'b1, 1'b0, 1'b1, 8'h00, e, t); endtask
    task automatic rreg(input logic [7:0] idx, input logic [7:0] e, input string t);
        wi(idx); rd(e, t);
    endtask
    task automatic wreg(input logic [7:0] idx, input logic [7:0] d);
        wi(idx); wd(d);
    endtask
    task automatic idle();
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask
    task automatic ri_both(input logic [7:0] em, input logic [7:0] ea, input string t);
        drive(1'b0, 1'b0, 1'b1, 8'h00, em, t);
        @(negedge clk);
        judge(rdata_alt, ea, t);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // reset state: sealed
        ri(8'hFF, "R4 reset index read");
        rd(8'hFF, "R4 reset data read");

        // R2: alternate base needs AA as final byte; main base rejects it
        wi(8'h87); wi(8'h01); wi(8'h55); wi(8'hAA);
        ri_both(8'hFF, 8'h00, "R2 final byte per base");
        wi(8'hAA);
        ri_both(8'hFF, 8'hFF, "R5 alt sealed by AA");

        // R4: sealed data write ignored (checked later via selector)
        wi(8'h07); wd(8'h05);

        // R3: repeated 87 restarts; R13 final byte with same-cycle index read
        wi(8'h87); wi(8'h01); wi(8'h87); wi(8'h01); wi(8'h55);
        drive(1'b0, 1'b1, 1'b1, 8'h55, 8'hFF, "R13 read during key completion");
        ri(8'h00, "R3 open after 87 restart, R4 index not stored");

        // R7 identity
        rreg(8'h20, 8'h87, "R7 id high");
        rreg(8'h21, 8'h12, "R7 id low");
        rreg(8'h22, 8'h03, "R7 version");
        ri(8'h22, "R12 index echo");

        // R8 selector; R4 sealed data write had no effect
        rreg(8'h07, 8'h00, "R4 selector untouched while sealed");
        wd(8'h01);
        rd(8'h01, "R8 selector readback");

        // R10 defaults
        rreg(8'h60, 8'h03, "R10 dev1 base hi");
        rreg(8'h61, 8'hF8, "R10 dev1 base lo");
        rreg(8'h70, 8'h04, "R10 dev1 irq");
        rreg(8'h30, 8'h00, "R10 dev1 enable");
        wreg(8'h07, 8'h02);
        rreg(8'h60, 8'h02, "R10 dev2 base hi");
        rreg(8'h61, 8'hF8, "R10 dev2 base lo");
        rreg(8'h70, 8'h03, "R10 dev2 irq");
        wreg(8'h07, 8'h00);
        rreg(8'h60, 8'h00, "R10 dev0 base hi");

        // R9 banked writes on dev2
        wreg(8'h07, 8'h02);
        wreg(8'h30, 8'hFF); rd(8'h01, "R9 enable bit only");
        wreg(8'h70, 8'h5A); rd(8'h0A, "R9 irq low nibble");
        wreg(8'h60, 8'h12); rd(8'h12, "R9 base hi write");
        wreg(8'h61, 8'h34); rd(8'h34, "R9 base lo write");
        wreg(8'h07, 8'h01);
        rreg(8'h60, 8'h03, "R9 dev1 independent of dev2");

        // R13 same-cycle data write and read; R1 data port reaches indexed reg
        wi(8'h61);
        drive(1'b1, 1'b1, 1'b1, 8'h77, 8'hF8, "R13 read sees old value");
        rd(8'h77, "R1 data write landed");

        // R11 unimplemented register and out-of-range selector
        rreg(8'h31, 8'hFF, "R11 unimplemented reg");
        wd(8'h00);
        rd(8'hFF, "R11 unimplemented reg write ignored");
        wreg(8'h07, 8'h0B);
        rd(8'h0B, "R11 out-of-range selector stored");
        rreg(8'h60, 8'hFF, "R11 banked read out of range");
        wd(8'h99);
        wreg(8'h07, 8'h00);
        rreg(8'h60, 8'h00, "R11 out-of-range write hit no device");
        wreg(8'h07, 8'h02);
        rreg(8'h60, 8'h12, "R11 dev2 kept value");

        // R6 control register
        rreg(8'h02, 8'h00, "R6 control reads zero");
        wd(8'h01);
        ri(8'h02, "R6 bit1 clear keeps open");
        wd(8'h02);
        ri(8'hFF, "R6 bit1 set seals");

        // R4: sealed index write not stored
        wi(8'h20);
        wi(8'h87); wi(8'h01); wi(8'h55); wi(8'h55);
        ri(8'h02, "R4 index kept across sealed writes");

        // R5 seal by AA with same-cycle index read
        drive(1'b0, 1'b1, 1'b1, 8'hAA, 8'h02, "R13 read during seal byte");
        ri(8'hFF, "R5 sealed by exit byte");
        rd(8'hFF, "R5 data port sealed");

        // R3 wrong non-87 byte resets detector
        wi(8'h87); wi(8'h01); wi(8'h33); wi(8'h55); wi(8'h55);
        ri(8'hFF, "R3 wrong byte resets key");
        wi(8'h87); wi(8'h01); wi(8'h55); wi(8'h55);
        ri(8'h02, "R2 clean key opens");

        idle();
        idle();
        if (exp_q.size() != 0) judge(8'(exp_q.size()), 8'h00, "scoreboard drained");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule